// File: doc/BRIEF.md
# Programmable Wake-Up Input Debouncer

This block qualifies a bank of asynchronous wake-up pins and one force-wake-up pin against a free-running slow clock. Each raw input first passes through a synchronizer. A small state machine per path then counts consecutive slow-clock samples in which the input is active. When the count reaches the length chosen for that path, the path raises a request. A 3-bit period code selects the length from a nonuniform set that runs from a single sample up to 32768 samples. The wake-up pins share one code and the force-wake-up pin has a separate code. Both codes live in a mode register, and a write-protect input can lock that register.

Every path runs the same four-state machine. ST_IDLE waits for an active sample. ST_COUNT accumulates consecutive active samples. ST_FIRE holds the request. ST_MUTE holds a cleared request low until the input goes inactive. The transitions are:
- idle→count on an active sample when the threshold exceeds one.
- idle→fire on an active sample when the threshold is one.
- count→fire when the sample count reaches the threshold.
- count→idle, fire→idle and mute→idle on any inactive sample.
- fire→mute when the clear pulse is high.

Each wake-up pin has its own enable bit and polarity bit. The force-wake-up pin is always enabled and is active high.

Top module: `wake_debounce`

## Requirements
- R1: The period code selects the threshold T, the number of consecutive active synchronized samples needed. Code 0 gives T=1, code 1 gives 3, code 2 gives 32, code 3 gives 512, code 4 gives 4096 and code 5 gives 32768. Suppose a raw input becomes active before clock edge k and stays active. Its request is then first high after edge k+T+1, which is T+2 edges counted from edge k, because two of those edges are spent in the synchronizer.
- R2: Codes 6 and 7 behave exactly like code 5 (T=32768).
- R3: The mode register holds the wake-up pin code in bits 14:12 and the force-wake-up code in bits 10:8. Each code affects only its own path.
- R4: A write with `cfg_we` high stores both codes only when `wp_en` is low. A write made while `wp_en` is high leaves both codes unchanged.
- R5: After reset both codes are 0, so every path uses immediate detection (T=1), and all requests are low.
- R6: One inactive synchronized sample returns a path to idle. Its request drops after the third edge following the raw release, and a later active stretch counts from zero again.
- R7: A high `req_clr` at a clock edge drops every asserted request after that edge. A cleared request stays low while its input remains active. After the input has been inactive for one sample, the path can fire again.
- R8: A wake-up pin whose bit in `pin_en` is low never asserts its request.
- R9: For pin i, `pin_pol[i]=1` makes a high level active and `pin_pol[i]=0` makes a low level active.
- R10: The force-wake-up pin is active high and has no enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_raw | input | NUM_PINS | Raw asynchronous wake-up pins |
| pin_en | input | NUM_PINS | Per-pin enable |
| pin_pol | input | NUM_PINS | Per-pin active level, 1 = high |
| force_raw | input | 1 | Raw force-wake-up pin, active high |
| cfg_we | input | 1 | Mode register write strobe |
| cfg_wdata | input | DATA_W | Mode register write data |
| wp_en | input | 1 | Write protect, high blocks writes |
| req_clr | input | 1 | Clear pulse for asserted requests |
| wake_req | output | NUM_PINS | Per-pin qualified wake-up request |
| force_req | output | 1 | Qualified force-wake-up request |

## Verification
The hardest behaviour to reach is the long end of the code table. Codes 5, 6 and 7 each need 32768 unbroken active samples. The bench therefore holds the input steady and measures the latency to the exact cycle, so that a reserved code mapped to the wrong length, or an off-by-one count, shows up as a latency mismatch. The mute state is reached only by clearing an asserted request while its input is still held active. The bench then keeps the input active, confirms that the request stays low, and confirms that the request re-arms only after the input has been released.

// File: rtl/wdb_pkg.sv
package wdb_pkg;
    localparam int CODE_W = 3;
    localparam int CNT_W  = 16;

    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [CODE_W-1:0] code_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_COUNT,
        ST_FIRE,
        ST_MUTE
    } flt_state_t;

    // Map a period code to the number of consecutive active samples.
    function automatic cnt_t code_to_thresh(input code_t c);
        cnt_t t;
        unique case (c)
            3'd0:             t = cnt_t'(1);
            3'd1:             t = cnt_t'(3);
            3'd2:             t = cnt_t'(32);
            3'd3:             t = cnt_t'(512);
            3'd4:             t = cnt_t'(4096);
            3'd5, 3'd6, 3'd7: t = cnt_t'(32768);
        endcase
        return t;
    endfunction
endpackage

// File: rtl/wdb_sync.sv
module wdb_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= din;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/wdb_cfg.sv
module wdb_cfg
    import wdb_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int WAKE_LSB  = 12,
    parameter int FORCE_LSB = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              wp_en,
    input  logic [DATA_W-1:0] cfg_wdata,
    output code_t             wake_code,
    output code_t             force_code
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wake_code  <= '0;
            force_code <= '0;
        end else if (cfg_we && !wp_en) begin
            wake_code  <= cfg_wdata[WAKE_LSB  +: CODE_W];
            force_code <= cfg_wdata[FORCE_LSB +: CODE_W];
        end
    end
endmodule

// File: rtl/wdb_filter.sv
module wdb_filter
    import wdb_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  act,
    input  logic  clr,
    input  code_t code,
    output logic  req
);
    flt_state_t state, state_nx;
    cnt_t       cnt, cnt_nx;
    cnt_t       thr;

    assign thr = code_to_thresh(code);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    // Next state
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            ST_IDLE: begin
                cnt_nx = '0;
                if (act) begin
                    if (thr <= cnt_t'(1)) begin
                        state_nx = ST_FIRE;
                    end else begin
                        state_nx = ST_COUNT;
                        cnt_nx   = cnt_t'(1);
                    end
                end
            end
            ST_COUNT: begin
                if (!act) begin
                    state_nx = ST_IDLE;
                    cnt_nx   = '0;
                end else if (cnt + cnt_t'(1) >= thr) begin
                    state_nx = ST_FIRE;
                    cnt_nx   = '0;
                end else begin
                    cnt_nx = cnt + cnt_t'(1);
                end
            end
            ST_FIRE: begin
                if (!act)     state_nx = ST_IDLE;
                else if (clr) state_nx = ST_MUTE;
            end
            ST_MUTE: begin
                if (!act) state_nx = ST_IDLE;
            end
        endcase
    end

    // Outputs
    always_comb begin
        req = (state == ST_FIRE);
    end
endmodule

// File: rtl/wake_debounce.sv
module wake_debounce
    import wdb_pkg::*;
#(
    parameter int NUM_PINS    = 4,
    parameter int SYNC_STAGES = 2,
    parameter int DATA_W      = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_raw,
    input  logic [NUM_PINS-1:0] pin_en,
    input  logic [NUM_PINS-1:0] pin_pol,
    input  logic                force_raw,
    input  logic                cfg_we,
    input  logic [DATA_W-1:0]   cfg_wdata,
    input  logic                wp_en,
    input  logic                req_clr,
    output logic [NUM_PINS-1:0] wake_req,
    output logic                force_req
);
    localparam int SYNC_W = NUM_PINS + 1;

    logic [SYNC_W-1:0]   sync_q;
    logic [NUM_PINS-1:0] pin_sync;
    logic                force_sync;
    code_t               wake_code;
    code_t               force_code;

    wdb_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({force_raw, pin_raw}),
        .dout  (sync_q)
    );

    assign pin_sync   = sync_q[NUM_PINS-1:0];
    assign force_sync = sync_q[NUM_PINS];

    wdb_cfg #(.DATA_W(DATA_W), .WAKE_LSB(12), .FORCE_LSB(8)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .wp_en      (wp_en),
        .cfg_wdata  (cfg_wdata),
        .wake_code  (wake_code),
        .force_code (force_code)
    );

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        logic act;
        assign act = pin_en[g] && (pin_sync[g] == pin_pol[g]);
        wdb_filter u_flt (
            .clk   (clk),
            .rst_n (rst_n),
            .act   (act),
            .clr   (req_clr),
            .code  (wake_code),
            .req   (wake_req[g])
        );
    end

    wdb_filter u_force (
        .clk   (clk),
        .rst_n (rst_n),
        .act   (force_sync),
        .clr   (req_clr),
        .code  (force_code),
        .req   (force_req)
    );
endmodule

// File: rtl/wdb_checker.sv
module wdb_checker
    import wdb_pkg::*;
#(
    parameter int NUM_PINS = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_PINS-1:0] pin_en,
    input logic [NUM_PINS-1:0] wake_req,
    input logic                force_req,
    input logic                force_sync,
    input logic                req_clr,
    input logic                cfg_we,
    input logic                wp_en,
    input code_t               wake_code,
    input code_t               force_code
);
    // R4: protected writes leave the stored codes untouched
    a_r4_protect_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && wp_en) |=> ($stable(wake_code) && $stable(force_code)));

    // R6: an inactive force sample removes the force request
    a_r6_inactive_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !force_sync |=> !force_req);

    // R7: clear on the force path
    a_r7_clear_force: assert property (@(posedge clk) disable iff (!rst_n)
        (req_clr && force_req) |=> !force_req);

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_chk
        // R8: disabled pin stays quiet
        a_r8_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            !pin_en[g] |=> !wake_req[g]);
        // R7: clear drops an asserted wake request
        a_r7_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
            (req_clr && wake_req[g]) |=> !wake_req[g]);
    end
endmodule

bind wake_debounce wdb_checker #(.NUM_PINS(NUM_PINS)) u_wdb_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_en     (pin_en),
    .wake_req   (wake_req),
    .force_req  (force_req),
    .force_sync (force_sync),
    .req_clr    (req_clr),
    .cfg_we     (cfg_we),
    .wp_en      (wp_en),
    .wake_code  (wake_code),
    .force_code (force_code)
);

// File: tb/test_wake_debounce.sv
module test_wake_debounce;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] pin_raw = '0;
    logic [N-1:0] pin_en = '1;
    logic [N-1:0] pin_pol = '1;
    logic         force_raw = 1'b0;
    logic         cfg_we = 1'b0;
    logic [15:0]  cfg_wdata = '0;
    logic         wp_en = 1'b0;
    logic         req_clr = 1'b0;
    logic [N-1:0] wake_req;
    logic         force_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    wake_debounce #(.NUM_PINS(N)) i_wake_debounce (
        .clk(clk), .rst_n(rst_n), .pin_raw(pin_raw), .pin_en(pin_en),
        .pin_pol(pin_pol), .force_raw(force_raw), .cfg_we(cfg_we),
        .cfg_wdata(cfg_wdata), .wp_en(wp_en), .req_clr(req_clr),
        .wake_req(wake_req), .force_req(force_req)
    );

    function automatic int thr_of(input int c);
        if (c == 0) return 1;
        if (c == 1) return 3;
        if (c == 2) return 32;
        if (c == 3) return 512;
        if (c == 4) return 4096;
        return 32768;
    endfunction

    function automatic bit req_of(input int sel);
        return (sel == N) ? force_req : wake_req[sel];
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Drive path sel to its active (v=1) or inactive (v=0) level.
    task automatic drive(input int sel, input bit v);
        if (sel == N) force_raw = v;
        else pin_raw[sel] = pin_pol[sel] ? v : ~v;
    endtask

    task automatic write_cfg(input int wc, input int fc);
        @(negedge clk);
        cfg_wdata = 16'((wc & 7) << 12) | 16'((fc & 7) << 8);
        cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Measure edges from raw activation to request, then release.
    task automatic measure(input int sel, input int exp_lat, input string tag);
        int lat = 0;
        @(negedge clk);
        drive(sel, 1'b1);
        for (int i = 0; i < exp_lat + 5; i++) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            if (req_of(sel)) break;
        end
        check(lat == exp_lat && req_of(sel), tag, lat, exp_lat);
        drive(sel, 1'b0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!req_of(sel), "R6 release drops request", int'(req_of(sel)), 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R5: reset state and immediate default
        check(wake_req == '0 && !force_req, "R5 reset outputs", int'({force_req, wake_req}), 0);
        measure(0, 3, "R5 default immediate pin");
        measure(N, 3, "R10 R5 default immediate force");

        // R4: protected write ignored
        wp_en = 1'b1;
        write_cfg(3, 3);
        wp_en = 1'b0;
        measure(0, 3, "R4 protected write ignored pin");
        measure(N, 3, "R4 protected write ignored force");

        // R1 R2 R3: wake code sweep, force code held at 0
        for (int c = 0; c < 8; c++) begin
            write_cfg(c, 0);
            measure(0, thr_of(c) + 2, (c >= 6) ? "R2 reserved wake code" : "R1 wake code latency");
            if (c < 4) measure(N, 3, "R3 force independent of wake code");
        end

        // R1 R2 R3: force code sweep, wake code held at 2
        for (int c = 0; c < 7; c++) begin
            if (c == 5) continue;
            write_cfg(2, c);
            measure(N, thr_of(c) + 2, (c == 6) ? "R2 reserved force code" : "R1 force code latency");
            if (c < 3) measure(1, 34, "R3 wake independent of force code");
        end

        // R1: every pin with code 1
        write_cfg(1, 0);
        for (int p = 0; p < N; p++) measure(p, 5, "R1 per-pin code 1");

        // R9: active-low polarity on pin 3
        @(negedge clk);
        pin_pol[3] = 1'b0;
        pin_raw[3] = 1'b1;
        repeat (5) @(negedge clk);
        check(!wake_req[3], "R9 high level inactive when pol=0", int'(wake_req[3]), 0);
        measure(3, 5, "R9 active-low latency");
        pin_pol[3] = 1'b1;
        pin_raw[3] = 1'b0;

        // R8: disabled pin never fires
        write_cfg(0, 0);
        @(negedge clk);
        pin_en[1] = 1'b0;
        pin_raw[1] = 1'b1;
        begin
            int seen = 0;
            for (int i = 0; i < 12; i++) begin
                @(negedge clk);
                if (wake_req[1]) seen++;
            end
            check(seen == 0, "R8 disabled pin quiet", seen, 0);
        end
        pin_raw[1] = 1'b0;
        pin_en[1] = 1'b1;
        repeat (4) @(negedge clk);

        // R6: restart after a one-sample gap
        write_cfg(2, 0);
        @(negedge clk);
        pin_raw[2] = 1'b1;
        repeat (20) @(negedge clk);
        check(!wake_req[2], "R6 partial count no request", int'(wake_req[2]), 0);
        pin_raw[2] = 1'b0;
        @(negedge clk);
        measure(2, 34, "R6 restart counts from zero");

        // R7: clear, mute while held, re-arm after release
        write_cfg(0, 0);
        @(negedge clk);
        pin_raw[1] = 1'b1;
        force_raw = 1'b1;
        repeat (3) @(negedge clk);
        check(wake_req[1] && force_req, "R7 fired before clear", int'({force_req, wake_req[1]}), 3);
        req_clr = 1'b1;
        @(negedge clk);
        req_clr = 1'b0;
        check(!wake_req[1] && !force_req, "R7 clear drops", int'({force_req, wake_req[1]}), 0);
        repeat (10) @(negedge clk);
        check(!wake_req[1] && !force_req, "R7 stays low while held", int'({force_req, wake_req[1]}), 0);
        pin_raw[1] = 1'b0;
        force_raw = 1'b0;
        repeat (4) @(negedge clk);
        measure(1, 3, "R7 re-arm after release");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule